// File: doc/BRIEF.md
# Pin Change Notification Controller

This block watches up to 24 input pins and raises an interrupt request when an enabled pin changes level. Each pin has an enable bit for change detection and an enable bit for a weak pull-up. The pins pass through a synchronizer and are compared against a stored snapshot. A difference on an enabled pin sets a sticky flag. Software clears the flag by writing 1 to the flag register. That same write refreshes the snapshot.

While `sleep` is high, the snapshot is frozen. A purely combinational comparison of the raw pins against the snapshot, masked by the enables, drives `wakeReq`. No clock is needed for this path, so the system can restart its clock from it. The first clock edge that sees `wakeReq` while still asleep loads the flag.

The block also drives one pull-up enable per pin to the pad ring. It forces that enable low whenever the pin is configured as a digital output.

Top module: `cn_top`

## Requirements
- R1: After reset, all enable and pull-up registers read 0, `irqReq` is 0 and `pullUpEn` is all zero.
- R2: The register map is as follows:
  - Address 0 holds the change enables for pins 15..0, in data bits 15..0.
  - Address 1 holds the change enables for pins 23..16, in data bits 7..0.
  - Address 2 holds the pull-up enables for pins 15..0.
  - Address 3 holds the pull-up enables for pins 23..16.
  - A write takes effect on the clock edge where `regWrEn` is high, and reads are combinational.
- R3: At addresses 1 and 3, data bits 15..8 ignore writes and read as 0. Addresses 5 to 7 read as 0.
- R4: While awake, a level change (either direction) on an enabled pin sets `irqReq`. The change must be held steady from before one rising edge, and `irqReq` is high after the third rising edge.
- R5: A level change on a pin whose change enable is 0 never sets `irqReq`.
- R6: The flag register behaves as follows:
  - The flag is sticky and reads at address 4, bit 0.
  - Writing 1 to bit 0 of address 4 clears it and refreshes the snapshot, so pin levels present at the clear do not set it again.
  - Writing 0 to that bit leaves it set.
- R7: `wakeReq` follows these rules:
  - While `sleep` is high, `wakeReq` goes high without any clock edge as soon as an enabled pin differs from the snapshot.
  - It stays low for changes on pins that are not enabled.
  - It is always low while `sleep` is low.
- R8: The first rising clock edge with `sleep` and `wakeReq` both high sets `irqReq`.
- R9: `pullUpEn[i]` equals pull-up enable bit i AND NOT `pinIsOutput[i]`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; may be stopped while asleep |
| rstN | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High while the system clock is gated off |
| pinIn | input | 24 | Raw pin levels |
| pinIsOutput | input | 24 | 1 where the pin is a digital output |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data |
| irqReq | output | 1 | Sticky change interrupt request |
| wakeReq | output | 1 | Clockless wake request while asleep |
| pullUpEn | output | 24 | Per-pin weak pull-up enable |

## Verification
The flag assertions assume that `sleep` changes only between clock edges, and that a pin change is held long enough for the synchronizer to pass it. The stimulus drives all inputs on falling edges and keeps each pin level for several cycles. The sleep check has two parts. With the clock stopped, it samples `wakeReq` after pin changes. It then restarts the clock with `sleep` still high and checks the first-edge flag load before dropping `sleep`.

// File: rtl/cn_pkg.sv
package cn_pkg;
  localparam int CN_ADDR_W = 3;

  typedef enum logic [CN_ADDR_W-1:0] {
    ADDR_EN_LO = 3'd0,
    ADDR_EN_HI = 3'd1,
    ADDR_PU_LO = 3'd2,
    ADDR_PU_HI = 3'd3,
    ADDR_FLAG  = 3'd4
  } cnAddrE;

  typedef struct packed {
    logic holdSnap;     // freeze snapshot, comparator drives wake path
    logic refreshSnap;  // reload snapshot from synchronized pins
  } cnStrobeT;
endpackage

// File: rtl/cn_datapath.sv
module cn_datapath
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  cnStrobeT            strobe,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsOutput,
  input  logic [NUM_PINS-1:0] enMask,
  input  logic [NUM_PINS-1:0] puMask,
  output logic                changeHit,
  output logic                wakeReq,
  output logic [NUM_PINS-1:0] pullUpEn
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncChain;
  logic [NUM_PINS-1:0] syncPins;
  logic [NUM_PINS-1:0] prevPins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign syncPins = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      prevPins <= '0;
    else if (strobe.refreshSnap || !strobe.holdSnap)
      prevPins <= syncPins;
  end

  // clocked detector, used while awake
  assign changeHit = !strobe.holdSnap && (|((syncPins ^ prevPins) & enMask));

  // clockless detector on raw pins, used while asleep
  assign wakeReq = strobe.holdSnap && (|((pinIn ^ prevPins) & enMask));

  assign pullUpEn = puMask & ~pinIsOutput;
endmodule

// File: rtl/cn_ctrl.sv
module cn_ctrl
  import cn_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int REG_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleep,
  input  logic                 regWrEn,
  input  logic [CN_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 changeHit,
  input  logic                 wakeReq,
  output logic [NUM_PINS-1:0]  enMask,
  output logic [NUM_PINS-1:0]  puMask,
  output cnStrobeT             strobe,
  output logic                 irqReq
);
  localparam int PAIR_W = 2 * REG_W;

  logic wrEnLo, wrEnHi, wrPuLo, wrPuHi, clrFlag;
  logic flag;
  logic [PAIR_W-1:0] enPad, puPad;

  assign wrEnLo  = regWrEn && (regAddr == ADDR_EN_LO);
  assign wrEnHi  = regWrEn && (regAddr == ADDR_EN_HI);
  assign wrPuLo  = regWrEn && (regAddr == ADDR_PU_LO);
  assign wrPuHi  = regWrEn && (regAddr == ADDR_PU_HI);
  assign clrFlag = regWrEn && (regAddr == ADDR_FLAG) && regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
      puMask <= '0;
    end else begin
      for (int b = 0; b < NUM_PINS; b++) begin
        if (b < REG_W) begin
          if (wrEnLo) enMask[b] <= regWrData[b % REG_W];
          if (wrPuLo) puMask[b] <= regWrData[b % REG_W];
        end else begin
          if (wrEnHi) enMask[b] <= regWrData[b % REG_W];
          if (wrPuHi) puMask[b] <= regWrData[b % REG_W];
        end
      end
    end
  end

  // a new event in the clear cycle wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           flag <= 1'b0;
    else if (changeHit || (sleep && wakeReq)) flag <= 1'b1;
    else if (clrFlag)                    flag <= 1'b0;
  end

  assign irqReq             = flag;
  assign strobe.holdSnap    = sleep;
  assign strobe.refreshSnap = clrFlag;

  always_comb begin
    enPad = '0;
    puPad = '0;
    enPad[NUM_PINS-1:0] = enMask;
    puPad[NUM_PINS-1:0] = puMask;
    regRdData = '0;
    case (regAddr)
      ADDR_EN_LO: regRdData = enPad[REG_W-1:0];
      ADDR_EN_HI: regRdData = enPad[PAIR_W-1:REG_W];
      ADDR_PU_LO: regRdData = puPad[REG_W-1:0];
      ADDR_PU_HI: regRdData = puPad[PAIR_W-1:REG_W];
      ADDR_FLAG:  regRdData[0] = flag;
      default:    regRdData = '0;
    endcase
  end

  // R4
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    changeHit |=> flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !clrFlag) |=> flag);

  // R8
  wake_loads_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && wakeReq) |=> flag);

  // R5
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !changeHit && !(sleep && wakeReq)) |=> !flag);
endmodule

// File: rtl/cn_top.sv
module cn_top
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleep,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic [NUM_PINS-1:0]  pinIsOutput,
  input  logic                 regWrEn,
  input  logic [CN_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqReq,
  output logic                 wakeReq,
  output logic [NUM_PINS-1:0]  pullUpEn
);
  cnStrobeT strobe;
  logic changeHit;
  logic [NUM_PINS-1:0] enMask, puMask;

  cn_ctrl #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sleep(sleep),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .changeHit(changeHit), .wakeReq(wakeReq),
    .enMask(enMask), .puMask(puMask), .strobe(strobe), .irqReq(irqReq)
  );

  cn_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pinIn(pinIn), .pinIsOutput(pinIsOutput),
    .enMask(enMask), .puMask(puMask),
    .changeHit(changeHit), .wakeReq(wakeReq), .pullUpEn(pullUpEn)
  );
endmodule

// File: tb/cn_top_test.sv
`timescale 1ns/1ps
module cn_top_test;
  logic        clk = 1'b0;
  logic        clkRun = 1'b1;
  logic        rstN = 1'b0;
  logic        sleep = 1'b0;
  logic [23:0] pinIn = '0;
  logic [23:0] pinIsOutput = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqReq, wakeReq;
  logic [23:0] pullUpEn;

  int nChecks = 0;
  int nFail = 0;

  cn_top uut (
    .clk(clk), .rstN(rstN), .sleep(sleep), .pinIn(pinIn),
    .pinIsOutput(pinIsOutput), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .wakeReq(wakeReq), .pullUpEn(pullUpEn)
  );

  always begin
    #2.5;
    if (clkRun) clk = ~clk;
  end

  // {toggle mask, enable mask}
  localparam logic [47:0] VECS [8] = '{
    {24'h000001, 24'h000001},
    {24'h000001, 24'h000002},
    {24'h800000, 24'h800000},
    {24'h800000, 24'h7FFFFF},
    {24'h0F0F0F, 24'hF0F0F0},
    {24'h0F0F0F, 24'h010000},
    {24'hFFFFFF, 24'hFFFFFF},
    {24'h000100, 24'h000100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 irq", {31'd0, irqReq}, 32'd0);
    chk("R1 pullUpEn", {8'd0, pullUpEn}, 32'd0);
    rdReg(3'd0, rd); chk("R1 enLo", {16'd0, rd}, 32'd0);
    rdReg(3'd1, rd); chk("R1 enHi", {16'd0, rd}, 32'd0);
    rdReg(3'd2, rd); chk("R1 puLo", {16'd0, rd}, 32'd0);

    // R2 / R3 register map
    wrReg(3'd0, 16'hA5C3);
    rdReg(3'd0, rd); chk("R2 enLo", {16'd0, rd}, 32'hA5C3);
    wrReg(3'd1, 16'hAB12);
    rdReg(3'd1, rd); chk("R3 enHi upper bits", {16'd0, rd}, 32'h0012);
    wrReg(3'd3, 16'hFFFF);
    rdReg(3'd3, rd); chk("R3 puHi upper bits", {16'd0, rd}, 32'h00FF);
    wrReg(3'd2, 16'h1234);
    rdReg(3'd2, rd); chk("R2 puLo", {16'd0, rd}, 32'h1234);
    wrReg(3'd6, 16'hFFFF);
    rdReg(3'd6, rd); chk("R3 unused addr", {16'd0, rd}, 32'd0);
    rdReg(3'd0, rd); chk("R3 unused write no effect", {16'd0, rd}, 32'hA5C3);

    // R9 pull-up gating
    wrReg(3'd2, 16'hFFFF);
    pinIsOutput = 24'h00F0F0;
    #0.5;
    chk("R9 gated", {8'd0, pullUpEn}, {8'd0, 24'hFF0F0F});
    pinIsOutput = 24'hFFFF00;
    #0.5;
    chk("R9 regated", {8'd0, pullUpEn}, {8'd0, 24'h0000FF});
    pinIsOutput = '0;

    // R4 / R5 vector table
    for (int v = 0; v < 8; v++) begin
      logic [23:0] tog, en;
      logic expIrq;
      tog = VECS[v][47:24];
      en  = VECS[v][23:0];
      expIrq = |(tog & en);
      wrReg(3'd0, en[15:0]);
      wrReg(3'd1, {8'd0, en[23:16]});
      wrReg(3'd4, 16'h0001);
      tick(2);
      chk("R6 cleared before vector", {31'd0, irqReq}, 32'd0);
      pinIn = pinIn ^ tog;
      tick(4);
      chk(expIrq ? "R4 enabled change" : "R5 disabled change",
          {31'd0, irqReq}, {31'd0, expIrq});
      if (v == 0) begin
        wrReg(3'd4, 16'h0000);
        rdReg(3'd4, rd);
        chk("R6 write 0 keeps flag", {16'd0, rd}, 32'd1);
      end
      wrReg(3'd4, 16'h0001);
      tick(4);
      chk("R6 clear stays clear", {31'd0, irqReq}, 32'd0);
    end

    // R4 change back to the old level also counts
    wrReg(3'd0, 16'h0004);
    wrReg(3'd1, 16'h0000);
    pinIn[2] = ~pinIn[2];
    tick(4);
    wrReg(3'd4, 16'h0001);
    tick(2);
    pinIn[2] = ~pinIn[2];
    tick(4);
    chk("R4 reverse edge", {31'd0, irqReq}, 32'd1);
    wrReg(3'd4, 16'h0001);
    tick(3);

    // R7 / R8 sleep path
    wrReg(3'd0, 16'h0020);
    tick(3);
    chk("R7 awake no wake", {31'd0, wakeReq}, 32'd0);
    @(negedge clk);
    sleep = 1'b1;
    clkRun = 1'b0;
    #20;
    chk("R7 asleep idle", {31'd0, wakeReq}, 32'd0);
    pinIn[6] = ~pinIn[6];
    #20;
    chk("R7 disabled pin asleep", {31'd0, wakeReq}, 32'd0);
    pinIn[5] = ~pinIn[5];
    #20;
    chk("R7 clockless wake", {31'd0, wakeReq}, 32'd1);
    chk("R8 no edge yet", {31'd0, irqReq}, 32'd0);
    clkRun = 1'b1;
    @(negedge clk);
    chk("R8 first edge loads flag", {31'd0, irqReq}, 32'd1);
    sleep = 1'b0;
    #0.5;
    chk("R7 awake forces low", {31'd0, wakeReq}, 32'd0);
    tick(4);
    wrReg(3'd4, 16'h0001);
    tick(4);
    chk("R6 clear after wake", {31'd0, irqReq}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule